// File: doc/BRIEF.md
# Gated Edge Pulse Driver

This block turns one transition of a slow, free-running control line (the shift input) into a single clean pulse on the system clock. The pulse fires only if a second line (the gate qualifier) is true at the moment of that transition. The shift line may move at any instant with no relation to the clock. For that reason the qualified transition is caught by a storage element clocked by the shift line itself. The capture is then carried into the clock domain through a short synchronizer and retired as a pulse exactly one clock cycle wide. If the gate is tied true, the block fires on every active transition and acts as a plain sample pulse driver.

Three per-instance parameters set the active transition (rising or falling), the output sense (active-high or active-low) and the sense of the DC reset. A fourth parameter sets the number of synchronizer stages. The pulse appears `SYNC_STAGES + 1` clock edges after the transition. With the default of two stages, that is on the third rising clock edge after the shift edge. The system clock is expected to run at a 20 ns period or faster.

Top module: `gated_pulse_driver`

## Requirements
- R1: While the DC reset is active, the output stays at its inactive level and shift transitions are discarded. No pulse appears after reset is released for a transition that happened during reset.
- R2: A rising shift edge (default setting) while the gate is true yields exactly one pulse. With `SYNC_STAGES` = 2 the pulse is present in the clock cycle that starts on the third rising clock edge after the shift edge.
- R3: Each pulse lasts exactly one clock cycle, however long the shift input stays high.
- R4: A shift edge seen while the gate is false yields no pulse, even if the gate turns true later while the shift input is still high.
- R5: With the gate held true, shift edges at least two clock cycles apart each yield their own pulse, so the pulse count equals the edge count.
- R6: With `TRIG_FALL` = 1 the block fires on falling shift edges, with the same latency as R2, and ignores rising shift edges.
- R7: With `OUT_LOW` = 1 the output idles at 1 and the pulse is a single-cycle 0.
- R8: With `RST_LOW` = 1 the DC reset is active when the input is 0.
- R9: Asserting the DC reset after an edge has been captured, but before its pulse has appeared, cancels that pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock that times pulse retirement |
| dc_rst_i | input | 1 | Asynchronous DC reset; its active level is set by `RST_LOW` |
| shift_i | input | 1 | Monitored line; its active transition is set by `TRIG_FALL` |
| gate_i | input | 1 | Qualifier, sampled at the shift transition |
| pulse_o | output | 1 | One-cycle pulse; its sense is set by `OUT_LOW` |

## Verification
The assertions check on every cycle that:
- a pulse is never wider than one cycle;
- a pulse only follows a change at the synchronizer output;
- the cycle after reset always shows the idle output level.

Only the bench scenarios can show the qualification of the gate at the shift edge (R4), the exact latency, cancellation by a late reset, and the polarity variants. Each of these depends on when the asynchronous stimulus arrives. The bench covers them with a behavioural queue model compared on every clock cycle.

// File: rtl/gpd_pkg.sv
package gpd_pkg;

    typedef struct packed {
        logic seen;   // last synchronized capture level
        logic pulse;  // active-high pulse flag
    } gpd_retire_t;

endpackage

// File: rtl/gpd_capture.sv
module gpd_capture #(
    parameter int TRIG_FALL = 0
) (
    input  logic shift_i,
    input  logic gate_i,
    input  logic rst_i,
    output logic tgl_o
);
    logic shift_eff;
    logic tgl_d;
    logic tgl_q;

    generate
        if (TRIG_FALL != 0) begin : g_fall
            assign shift_eff = ~shift_i;
        end else begin : g_rise
            assign shift_eff = shift_i;
        end
    endgenerate

    // A qualified edge flips the capture level; a disqualified one leaves it.
    always_comb begin
        tgl_d = tgl_q ^ gate_i;
    end

    always_ff @(posedge shift_eff or posedge rst_i) begin
        if (rst_i) tgl_q <= 1'b0;
        else       tgl_q <= tgl_d;
    end

    assign tgl_o = tgl_q;
endmodule

// File: rtl/gpd_sync.sv
module gpd_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_d;
    logic [STAGES-1:0] chain_q;

    always_comb begin
        chain_d = (chain_q << 1) | STAGES'(d_i);
    end

    always_ff @(posedge clk_i or posedge rst_i) begin
        if (rst_i) chain_q <= '0;
        else       chain_q <= chain_d;
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/gpd_retire.sv
module gpd_retire
    import gpd_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  logic lvl_i,
    output logic pulse_o
);
    gpd_retire_t st_d;
    gpd_retire_t st_q;

    always_comb begin
        st_d       = st_q;
        st_d.seen  = lvl_i;
        st_d.pulse = lvl_i ^ st_q.seen;
    end

    always_ff @(posedge clk_i or posedge rst_i) begin
        if (rst_i) st_q <= '0;
        else       st_q <= st_d;
    end

    assign pulse_o = st_q.pulse;
endmodule

// File: rtl/gated_pulse_driver.sv
module gated_pulse_driver #(
    parameter int TRIG_FALL   = 0,
    parameter int OUT_LOW     = 0,
    parameter int RST_LOW     = 0,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic dc_rst_i,
    input  logic shift_i,
    input  logic gate_i,
    output logic pulse_o
);
    logic rst_act;
    logic tgl_async;
    logic tgl_sync;
    logic pulse_act;

    generate
        if (RST_LOW != 0) begin : g_rst_low
            assign rst_act = ~dc_rst_i;
        end else begin : g_rst_high
            assign rst_act = dc_rst_i;
        end
    endgenerate

    gpd_capture #(.TRIG_FALL(TRIG_FALL)) u_capture (
        .shift_i (shift_i),
        .gate_i  (gate_i),
        .rst_i   (rst_act),
        .tgl_o   (tgl_async)
    );

    gpd_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i (clk_i),
        .rst_i (rst_act),
        .d_i   (tgl_async),
        .q_o   (tgl_sync)
    );

    gpd_retire u_retire (
        .clk_i   (clk_i),
        .rst_i   (rst_act),
        .lvl_i   (tgl_sync),
        .pulse_o (pulse_act)
    );

    generate
        if (OUT_LOW != 0) begin : g_out_low
            assign pulse_o = ~pulse_act;
        end else begin : g_out_high
            assign pulse_o = pulse_act;
        end
    endgenerate
endmodule

// File: rtl/gpd_checker.sv
module gpd_checker #(
    parameter int OUT_LOW = 0
) (
    input logic clk_i,
    input logic rst_act,
    input logic tgl_sync,
    input logic pulse_act,
    input logic pulse_o
);
    localparam logic IDLE_LVL = (OUT_LOW != 0);

    AST_PULSE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (rst_act)
        pulse_act |=> !pulse_act); // R3

    AST_PULSE_NEEDS_CHANGE: assert property (@(posedge clk_i) disable iff (rst_act)
        pulse_act |-> ($past(tgl_sync) != $past(tgl_sync, 2))); // R2

    AST_QUIET_AFTER_RESET: assert property (@(posedge clk_i) disable iff (rst_act)
        $past(rst_act) |-> !pulse_act); // R1

    AST_IDLE_LEVEL: assert property (@(posedge clk_i) disable iff (rst_act)
        $past(rst_act) |-> (pulse_o == IDLE_LVL)); // R7
endmodule

bind gated_pulse_driver gpd_checker #(.OUT_LOW(OUT_LOW)) u_gpd_chk (
    .clk_i     (clk_i),
    .rst_act   (rst_act),
    .tgl_sync  (tgl_sync),
    .pulse_act (pulse_act),
    .pulse_o   (pulse_o)
);

// File: tb/gated_pulse_driver_bench.sv
module gated_pulse_driver_bench;
    localparam int SYNC = 2;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst = 1'b1, shift_a = 1'b0, gate_a = 1'b0, out_a;
    logic rst_n = 1'b0, shift_b = 1'b1, gate_b = 1'b0, out_b;

    gated_pulse_driver #(.SYNC_STAGES(SYNC)) u_gated_pulse_driver (
        .clk_i(clk), .dc_rst_i(rst), .shift_i(shift_a), .gate_i(gate_a), .pulse_o(out_a));

    gated_pulse_driver #(.TRIG_FALL(1), .OUT_LOW(1), .RST_LOW(1), .SYNC_STAGES(SYNC))
        u_gated_pulse_driver_alt (
        .clk_i(clk), .dc_rst_i(rst_n), .shift_i(shift_b), .gate_i(gate_b), .pulse_o(out_b));

    int checks = 0, fails = 0;
    int cnt_a = 0, cnt_b = 0;
    string req_a = "R1", req_b = "R8";

    // Behavioural reference: queued countdowns per qualified edge
    int qa[$], qb[$];
    bit pend_a = 0, pend_b = 0;
    logic exp_a = 1'b0, exp_b = 1'b0;

    always @(posedge shift_a) if (gate_a && !rst) pend_a = 1;
    always @(negedge shift_b) if (gate_b && rst_n) pend_b = 1;

    always @(posedge clk) begin
        exp_a = 1'b0;
        if (rst) begin qa.delete(); pend_a = 0; end
        else begin
            for (int i = 0; i < qa.size(); i++) qa[i]--;
            while (qa.size() > 0 && qa[0] == 0) begin void'(qa.pop_front()); exp_a = 1'b1; end
            if (pend_a) begin qa.push_back(SYNC); pend_a = 0; end
        end
        exp_b = 1'b0;
        if (!rst_n) begin qb.delete(); pend_b = 0; end
        else begin
            for (int i = 0; i < qb.size(); i++) qb[i]--;
            while (qb.size() > 0 && qb[0] == 0) begin void'(qb.pop_front()); exp_b = 1'b1; end
            if (pend_b) begin qb.push_back(SYNC); pend_b = 0; end
        end
    end

    task automatic check(input bit ok, input string req, input logic act, input logic expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, expv, $time);
        end
    endtask

    task automatic check_cnt(input string req, input int act, input int expv);
        checks++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s: actual count %0d expected %0d", req, act, expv);
        end
    endtask

    always @(negedge clk) begin
        check(out_a === exp_a, req_a, out_a, exp_a);
        check(out_b === ~exp_b, req_b, out_b, ~exp_b);
        if (out_a === 1'b1) cnt_a++;
        if (out_b === 1'b0) cnt_b++;
    end

    task automatic step(input int n);
        repeat (n) begin @(negedge clk); #2; end
    endtask

    initial begin
        // R1: edges during reset are discarded
        req_a = "R1"; req_b = "R8";
        step(1);
        check(out_a === 1'b0, "R1", out_a, 1'b0);
        check(out_b === 1'b1, "R7", out_b, 1'b1);
        gate_a = 1; gate_b = 1;
        for (int i = 0; i < 3; i++) begin
            shift_a = 1; shift_b = 0; step(2); shift_a = 0; shift_b = 1; step(2);
        end
        rst = 0;
        step(8);
        check_cnt("R1", cnt_a, 0);

        // R2: single qualified edge, latency
        req_a = "R2"; cnt_a = 0;
        shift_a = 1; step(1);
        check(out_a === 1'b0, "R2", out_a, 1'b0);
        step(2);
        check(out_a === 1'b1, "R2", out_a, 1'b1);
        // R3: shift held high, pulse only one cycle wide
        req_a = "R3";
        step(1);
        check(out_a === 1'b0, "R3", out_a, 1'b0);
        step(10);
        check_cnt("R3", cnt_a, 1);
        shift_a = 0; step(6);

        // R4: gate false at the edge, then true while shift high
        req_a = "R4"; cnt_a = 0;
        gate_a = 0; step(1);
        shift_a = 1; step(2);
        gate_a = 1; step(8);
        check_cnt("R4", cnt_a, 0);
        shift_a = 0; step(4);

        // R5: gate tied true, train of edges
        req_a = "R5"; cnt_a = 0;
        for (int i = 0; i < 8; i++) begin
            shift_a = 1; step(1); shift_a = 0; step(1);
        end
        step(8);
        check_cnt("R5", cnt_a, 8);

        // R9: reset after capture cancels the pulse
        req_a = "R9"; cnt_a = 0;
        shift_a = 1; step(1);
        rst = 1; step(2);
        rst = 0; step(8);
        check_cnt("R9", cnt_a, 0);
        shift_a = 0; step(4);

        // R8: active-low reset released on the alternate instance
        rst_n = 1; step(6);
        check(out_b === 1'b1, "R8", out_b, 1'b1);

        // R6/R7: falling edges fire, rising edges do not
        req_b = "R6"; cnt_b = 0;
        shift_b = 0; step(3);
        check(out_b === 1'b0, "R7", out_b, 1'b0);
        step(1);
        check(out_b === 1'b1, "R7", out_b, 1'b1);
        step(4);
        shift_b = 1; step(8);
        check_cnt("R6", cnt_b, 1);

        // R6: gate false at a falling edge
        gate_b = 0; step(1); shift_b = 0; step(2); gate_b = 1; step(6);
        check_cnt("R6", cnt_b, 1);
        shift_b = 1; step(4);

        // R8: active-low reset cancels a captured edge
        req_b = "R8"; cnt_b = 0;
        shift_b = 0; step(1); rst_n = 0; step(2); rst_n = 1; step(8);
        check_cnt("R8", cnt_b, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule